// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day value for packet timestamp capture. It holds 40 bits of whole nanoseconds and a 32-bit sub-nanosecond fraction. On each pulse of an 8 ns reference tick, the value grows by a fixed 8 ns. A signed fractional correction is then added to or taken from that step. Software uses the correction to speed up or slow down the clock in very small steps, and it never changes the nominal step.

A narrow 32-bit register port gives software access to the time, the rate correction and a run/stop control. Multi-word accesses are made atomic in two ways:

- **Reads:** a read of the fraction word freezes the nanosecond count in a shadow copy. The low and high nanosecond reads that follow return that frozen copy.
- **Writes:** the low nanosecond word, and optionally the fraction, are staged first. The write of the high word then loads all of them in one cycle.

The live time is exported on dedicated outputs for the capture logic.

Top module: `fine_time_counter`

## Requirements
- R1: Word offsets on the register port are 0 = fraction, 1 = nanoseconds 31:0, 2 = nanoseconds 39:32, 3 = rate correction, 4 = control. After reset the time, fraction, rate correction and shadow copy are all zero, and control reads 0x8000_0000.
- R2: The counter only advances while control bit 31 is 0. Writing 0 there starts it and writing 1 stops it. Control bits 30:0 always read as zero.
- R3: With a zero correction magnitude, each tick while running adds exactly 8 ns and leaves the fraction unchanged. The carry crosses the 32-bit word boundary inside the nanosecond field.
- R4: Rate correction bits 30:0 are a magnitude in units of 2^-32 ns per tick. With bit 31 = 0 the magnitude is added to the fraction on each tick, and a carry out of the fraction adds 1 ns. The register reads back as written.
- R5: With rate correction bit 31 = 1 the magnitude is subtracted from the fraction on each tick, and a borrow removes 1 ns from that tick's 8 ns step.
- R6: The nanosecond field wraps modulo 2^40.
- R7: A read of the fraction word returns the live fraction and copies the live nanosecond count into the shadow. Reads of offsets 1 and 2 return the shadow, not the live count.
- R8: A read of offset 2 returns nanosecond bits 39:32 in bits 7:0 and zero in bits 31:8. Bits 31:8 of a write to offset 2 are ignored.
- R9: A write to offset 1 and a write to offset 0 are only staged. A write to offset 2 loads the staged low word, the written high bits and the staged fraction together. If no fraction was staged since the last load, the fraction loads as zero.
- R10: When the loading write to offset 2 falls in the same cycle as a tick, the loaded value wins and that tick adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per 8 ns reference period |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (a fraction read latches the shadow) |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, valid in the cycle of the read strobe |
| time_ns_o | output | 40 | Live nanosecond count |
| time_frac_o | output | 32 | Live sub-nanosecond fraction |
| running_o | output | 1 | High while the counter is enabled |

## Verification
The bench targets these corner cases:

- **Carry and wrap:** the fraction-to-nanosecond carry and the subtract borrow, where a design that ignored them would drift by whole nanoseconds or gain one on negative trims. The wrap at 2^40 and the carry across bit 32 of the nanoseconds are also checked; a wrong carry chain shows a corrupted high byte.
- **Shadow copy:** reads of the nanosecond words after the live count has moved on. A design that reads live values there returns the later time.
- **Staged loads:** a loading write that collides with a tick, which would show 8 ns too much if the increment won. A second load without a fraction write, where a stale staged fraction would reappear.

// File: rtl/fine_time_pkg.sv
package fine_time_pkg;

  parameter int unsigned TC_NS_W   = 40;
  parameter int unsigned TC_FRAC_W = 32;
  parameter int unsigned TC_DATA_W = 32;
  parameter int unsigned TC_ADDR_W = 3;
  parameter int unsigned TC_STEP   = 8;

  localparam int unsigned TC_T_W  = TC_NS_W + TC_FRAC_W;
  localparam int unsigned TC_HI_W = TC_NS_W - TC_DATA_W;

  typedef enum logic [TC_ADDR_W-1:0] {
    TC_A_FRAC = 3'd0,
    TC_A_NSLO = 3'd1,
    TC_A_NSHI = 3'd2,
    TC_A_RATE = 3'd3,
    TC_A_CTRL = 3'd4
  } tc_addr_e;

  // One tick of the combined {ns, fraction} value: nominal step plus or
  // minus the signed-magnitude correction, modulo the full width.
  function automatic logic [TC_T_W-1:0] tc_advance(
    input logic [TC_T_W-1:0]    cur,
    input logic [TC_DATA_W-1:0] adj
  );
    logic [TC_T_W-1:0] nominal;
    logic [TC_T_W-1:0] corr;
    nominal = {TC_NS_W'(TC_STEP), {TC_FRAC_W{1'b0}}};
    corr    = TC_T_W'(adj[TC_DATA_W-2:0]);
    if (adj[TC_DATA_W-1]) return cur + nominal - corr;
    else                  return cur + nominal + corr;
  endfunction

endpackage

// File: rtl/tc_regs.sv
module tc_regs
  import fine_time_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [TC_ADDR_W-1:0]  bus_addr_i,
  input  logic [TC_DATA_W-1:0]  bus_wdata_i,
  output logic [TC_DATA_W-1:0]  bus_rdata_o,
  input  logic [TC_NS_W-1:0]    live_ns_i,
  input  logic [TC_FRAC_W-1:0]  live_frac_i,
  output logic [TC_DATA_W-1:0]  rate_o,
  output logic                  run_o,
  output logic                  load_en_o,
  output logic [TC_NS_W-1:0]    load_ns_o,
  output logic [TC_FRAC_W-1:0]  load_frac_o,
  output logic                  latch_evt_o,
  output logic [TC_NS_W-1:0]    shadow_ns_o
);

  logic [TC_DATA_W-1:0] stage_lo_q;
  logic [TC_FRAC_W-1:0] stage_frac_q;
  logic [TC_DATA_W-1:0] rate_q;
  logic                 halt_q;
  logic [TC_NS_W-1:0]   shadow_q;

  logic wr_frac, wr_lo, wr_hi, wr_rate, wr_ctrl;

  always_comb begin
    wr_frac = bus_wr_i && (bus_addr_i == TC_A_FRAC);
    wr_lo   = bus_wr_i && (bus_addr_i == TC_A_NSLO);
    wr_hi   = bus_wr_i && (bus_addr_i == TC_A_NSHI);
    wr_rate = bus_wr_i && (bus_addr_i == TC_A_RATE);
    wr_ctrl = bus_wr_i && (bus_addr_i == TC_A_CTRL);
  end

  assign latch_evt_o = bus_rd_i && (bus_addr_i == TC_A_FRAC);
  assign load_en_o   = wr_hi;
  assign load_ns_o   = {bus_wdata_i[TC_HI_W-1:0], stage_lo_q};
  assign load_frac_o = stage_frac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo_q   <= '0;
      stage_frac_q <= '0;
      rate_q       <= '0;
      halt_q       <= 1'b1;
      shadow_q     <= '0;
    end else begin
      if (wr_lo)   stage_lo_q <= bus_wdata_i;
      if (wr_frac) stage_frac_q <= bus_wdata_i[TC_FRAC_W-1:0];
      else if (wr_hi) stage_frac_q <= '0;
      if (wr_rate) rate_q <= bus_wdata_i;
      if (wr_ctrl) halt_q <= bus_wdata_i[TC_DATA_W-1];
      if (latch_evt_o) shadow_q <= live_ns_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      case (bus_addr_i)
        TC_A_FRAC: bus_rdata_o = TC_DATA_W'(live_frac_i);
        TC_A_NSLO: bus_rdata_o = shadow_q[TC_DATA_W-1:0];
        TC_A_NSHI: bus_rdata_o = {{(TC_DATA_W-TC_HI_W){1'b0}}, shadow_q[TC_NS_W-1:TC_DATA_W]};
        TC_A_RATE: bus_rdata_o = rate_q;
        TC_A_CTRL: bus_rdata_o = {halt_q, {(TC_DATA_W-1){1'b0}}};
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign rate_o      = rate_q;
  assign run_o       = !halt_q;
  assign shadow_ns_o = shadow_q;

endmodule

// File: rtl/tc_accum.sv
module tc_accum
  import fine_time_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_en_i,
  input  logic                  load_en_i,
  input  logic [TC_NS_W-1:0]    load_ns_i,
  input  logic [TC_FRAC_W-1:0]  load_frac_i,
  input  logic [TC_DATA_W-1:0]  rate_i,
  output logic [TC_NS_W-1:0]    ns_o,
  output logic [TC_FRAC_W-1:0]  frac_o
);

  logic [TC_T_W-1:0] time_q;
  logic [TC_T_W-1:0] time_next;

  assign time_next = tc_advance(time_q, rate_i);

  always_ff @(posedge clk) begin
    if (!rst_n)         time_q <= '0;
    else if (load_en_i) time_q <= {load_ns_i, load_frac_i};
    else if (adv_en_i)  time_q <= time_next;
  end

  assign ns_o   = time_q[TC_T_W-1:TC_FRAC_W];
  assign frac_o = time_q[TC_FRAC_W-1:0];

endmodule

// File: rtl/fine_time_counter.sv
module fine_time_counter
  import fine_time_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [TC_ADDR_W-1:0]  bus_addr_i,
  input  logic [TC_DATA_W-1:0]  bus_wdata_i,
  output logic [TC_DATA_W-1:0]  bus_rdata_o,
  output logic [TC_NS_W-1:0]    time_ns_o,
  output logic [TC_FRAC_W-1:0]  time_frac_o,
  output logic                  running_o
);

  logic [TC_DATA_W-1:0] rate_q;
  logic                 run;
  logic                 load_en;
  logic [TC_NS_W-1:0]   load_ns;
  logic [TC_FRAC_W-1:0] load_frac;
  logic                 latch_evt;
  logic [TC_NS_W-1:0]   shadow_ns;
  logic                 adv_en;

  // A loading write suppresses the increment of a coincident tick.
  assign adv_en = run && tick_i && !load_en;

  tc_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .live_ns_i   (time_ns_o),
    .live_frac_i (time_frac_o),
    .rate_o      (rate_q),
    .run_o       (run),
    .load_en_o   (load_en),
    .load_ns_o   (load_ns),
    .load_frac_o (load_frac),
    .latch_evt_o (latch_evt),
    .shadow_ns_o (shadow_ns)
  );

  tc_accum u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_en_i    (adv_en),
    .load_en_i   (load_en),
    .load_ns_i   (load_ns),
    .load_frac_i (load_frac),
    .rate_i      (rate_q),
    .ns_o        (time_ns_o),
    .frac_o      (time_frac_o)
  );

  assign running_o = run;

endmodule

// File: rtl/tc_checker.sv
module tc_checker
  import fine_time_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd_i,
  input logic [TC_ADDR_W-1:0] bus_addr_i,
  input logic [TC_DATA_W-1:0] bus_rdata_o,
  input logic [TC_NS_W-1:0]   time_ns_o,
  input logic [TC_FRAC_W-1:0] time_frac_o,
  input logic                 running_o,
  input logic                 adv_en,
  input logic                 load_en,
  input logic [TC_NS_W-1:0]   load_ns,
  input logic [TC_FRAC_W-1:0] load_frac,
  input logic [TC_DATA_W-1:0] rate_q,
  input logic                 latch_evt,
  input logic [TC_NS_W-1:0]   shadow_ns
);

  a_r2_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !load_en) |=> ($stable(time_ns_o) && $stable(time_frac_o)));

  a_r3_nominal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && rate_q[TC_DATA_W-2:0] == '0) |=>
      (time_ns_o == $past(time_ns_o) + TC_NS_W'(TC_STEP) && $stable(time_frac_o)));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (time_ns_o == $past(load_ns) && time_frac_o == $past(load_frac)));

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(shadow_ns));

  a_r8_hi_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == TC_A_NSHI) |-> bus_rdata_o[TC_DATA_W-1:TC_HI_W] == '0);

endmodule

bind fine_time_counter tc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .time_ns_o   (time_ns_o),
  .time_frac_o (time_frac_o),
  .running_o   (running_o),
  .adv_en      (adv_en),
  .load_en     (load_en),
  .load_ns     (load_ns),
  .load_frac   (load_frac),
  .rate_q      (rate_q),
  .latch_evt   (latch_evt),
  .shadow_ns   (shadow_ns)
);

// File: tb/fine_time_counter_test.sv
module fine_time_counter_test;

  localparam logic [2:0] A_FRAC = 3'd0;
  localparam logic [2:0] A_LO   = 3'd1;
  localparam logic [2:0] A_HI   = 3'd2;
  localparam logic [2:0] A_RATE = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] t_ns;
  logic [31:0] t_frac;
  logic        running;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [39:0] m_ns;
  logic [31:0] m_frac;
  logic [31:0] m_rate;

  always #10 clk = ~clk;

  fine_time_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .time_ns_o(t_ns), .time_frac_o(t_frac), .running_o(running)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // Bench model of one tick, written as separate fraction and ns arithmetic.
  task automatic model_tick();
    logic [32:0] f;
    if (m_rate[31]) begin
      f = {1'b0, m_frac} - {2'b0, m_rate[30:0]};
      m_ns = m_ns + 40'd8 - {39'd0, f[32]};
    end else begin
      f = {1'b0, m_frac} + {2'b0, m_rate[30:0]};
      m_ns = m_ns + 40'd8 + {39'd0, f[32]};
    end
    m_frac = f[31:0];
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (running) model_tick();
    end
    tick = 1'b0;
  endtask

  task automatic load(input logic [39:0] ns);
    bus_write(A_LO, ns[31:0]);
    bus_write(A_HI, {24'hA5A5A5, ns[39:32]});
    m_ns = ns; m_frac = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 ns after reset", t_ns, 0);
    check("R1 running after reset", running, 0);
    bus_read(A_CTRL, d); check("R1 control reset", d, 32'h8000_0000);
    bus_read(A_RATE, d); check("R1 rate reset", d, 0);
    bus_read(A_FRAC, d); check("R1 fraction reset", d, 0);
    bus_read(A_LO, d);   check("R1 ns low reset", d, 0);
    bus_read(A_HI, d);   check("R1 ns high reset", d, 0);
    ticks(4);
    check("R2 halted ticks ignored", t_ns, 0);
  endtask

  task automatic t_nominal();
    bus_write(A_CTRL, 32'h0);
    check("R2 running after enable", running, 1);
    m_ns = 0; m_frac = 0; m_rate = 0;
    ticks(5);
    check("R3 five nominal ticks", t_ns, 40);
    check("R3 fraction unchanged", t_frac, 0);
  endtask

  task automatic t_load_high();
    logic [31:0] d;
    load(40'h7F_FFFF_FFF8);
    check("R9 loaded ns", t_ns, 40'h7F_FFFF_FFF8);
    bus_read(A_FRAC, d);
    bus_read(A_HI, d); check("R8 high word reserved zero", d, 32'h7F);
    bus_read(A_LO, d); check("R7 low word via shadow", d, 32'hFFFF_FFF8);
    ticks(1);
    check("R3 carry into ns bit 32", t_ns, 40'h80_0000_0000);
  endtask

  task automatic t_wrap();
    load(40'hFF_FFFF_FFFC);
    ticks(1);
    check("R6 wrap modulo 2^40", t_ns, 40'd4);
  endtask

  task automatic t_pos_adj();
    logic [31:0] d;
    m_rate = 32'h4000_0000;
    bus_write(A_RATE, m_rate);
    bus_read(A_RATE, d); check("R4 rate read back", d, m_rate);
    load(0);
    ticks(1);
    check("R4 ns after one trimmed tick", t_ns, 8);
    check("R4 fraction grows", t_frac, 32'h4000_0000);
    ticks(3);
    check("R4 carry from fraction", t_ns, m_ns);
    check("R4 carry leaves fraction", t_frac, m_frac);
    check("R4 absolute 33 ns", t_ns, 33);
  endtask

  task automatic t_neg_adj();
    m_rate = 32'hC000_0000;
    bus_write(A_RATE, m_rate);
    load(0);
    ticks(1);
    check("R5 borrow removes 1 ns", t_ns, 7);
    check("R5 fraction after borrow", t_frac, 32'hC000_0000);
    ticks(3);
    check("R5 ns after four ticks", t_ns, m_ns);
    check("R5 fraction after four ticks", t_frac, m_frac);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    m_rate = 0;
    bus_write(A_RATE, 0);
    load(100);
    bus_read(A_FRAC, d);
    ticks(3);
    check("R7 live time moved", t_ns, 124);
    bus_read(A_LO, d); check("R7 low read returns frozen copy", d, 100);
    bus_read(A_FRAC, d);
    bus_read(A_LO, d); check("R7 new latch refreshes copy", d, 124);
  endtask

  task automatic t_collision();
    bus_write(A_LO, 500);
    bus_write(A_HI, 0, 1'b1);
    check("R10 load beats tick", t_ns, 500);
    m_ns = 500; m_frac = 0;
  endtask

  task automatic t_frac_optional();
    bus_write(A_FRAC, 32'h1234_5678);
    bus_write(A_LO, 7);
    bus_write(A_HI, 0);
    check("R9 staged fraction loaded", t_frac, 32'h1234_5678);
    check("R9 staged ns loaded", t_ns, 7);
    bus_write(A_LO, 9);
    bus_write(A_HI, 0);
    check("R9 unstaged fraction loads zero", t_frac, 0);
    m_ns = 9; m_frac = 0;
  endtask

  task automatic t_stop();
    logic [31:0] d;
    bus_write(A_CTRL, 32'h8000_0000);
    check("R2 stopped", running, 0);
    ticks(6);
    check("R2 stopped time holds", t_ns, 9);
    bus_write(A_CTRL, 32'h0000_00FF);
    check("R2 restart with bit 31 clear", running, 1);
    bus_read(A_CTRL, d); check("R2 control low bits read zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_load_high();
    t_wrap();
    t_pos_adj();
    t_neg_adj();
    t_shadow();
    t_collision();
    t_frac_optional();
    t_stop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule